// File: doc/BRIEF.md
# Eight-bit Timer with Output Compare and PWM

This block is an eight-bit timer/counter for a peripheral subsystem. A prescaler outside the block supplies a one-cycle count-enable pulse. On every such pulse the counter takes one step, as long as the run bit is set. Software reaches four registers through a simple word bus: the count, the compare value, a control byte and an interrupt flag byte. The count is compared with the compare value all the time. A match raises a compare flag, and a wrap of the counter raises an overflow flag.

With PWM enabled, the block drives one waveform pin and offers two sub-modes. In fast mode the counter wraps at the top value, and each period lasts 256 steps. In phase-correct mode the counter climbs to the top and then comes back down, giving a symmetric waveform with a period of 510 steps. When software writes the count, the block ignores any compare match on the step that follows. Seeding the counter therefore never raises a spurious event. In PWM mode, a new compare value is held in a buffer until the counter passes the top value, so that no pulse on the pin is ever cut short.

Top module: `tc8_cmp_pwm`

## Requirements
- R1: After a synchronous reset, every register reads zero, both flag outputs and `pwm_out` are low, and `bus_rdata` is zero.
- R2: The bus addresses are 0 for count, 1 for compare, 2 for control and 3 for flags. The control bits are bit0 run, bit1 PWM enable, bit2 phase-correct select and bit3 output invert, and its upper bits read as zero. In the flag byte, bit0 is the compare flag and bit1 the overflow flag. `bus_rdata` shows the register selected by `bus_addr` in the previous cycle, with the value it held then.
- R3: The counter takes one step only in a cycle where `tick` is 1 and run is 1. In every other cycle it holds its value.
- R4: A write to address 0 loads the count at that clock edge and takes priority over a step in the same cycle. The next step continues from the written value.
- R5: After a write to the count, the next stepping cycle produces no compare match, even when the count equals the compare value.
- R6: A stepping cycle in which the count equals the active compare value records a compare event at that edge. The compare flag (`irq_cmp`) then rises at the following edge, two edges after the tick cycle.
- R7: Outside phase-correct mode the counter counts up and wraps from 0xFF to 0x00, and a wrap sets the overflow flag with the same two-edge timing as R6. In phase-correct mode, the overflow flag is set instead by the step that turns the counter at 0x00.
- R8: In fast PWM mode, a compare match clears the waveform and a wrap sets it. When both fall on the same step, the set wins.
- R9: In phase-correct mode the counter runs 0x00 up to 0xFF and back down to 0x00, moving by exactly one per step. A match while counting up clears the waveform, and a match while counting down sets it.
- R10: `pwm_out` is the waveform state, registered one edge later and inverted when bit3 is set. With PWM disabled, `pwm_out` is low and the waveform state is preset high.
- R11: With PWM disabled, a compare write takes effect at once. In PWM mode it is buffered and becomes active on the step taken from count 0xFF. Reads of address 1 always return the value last written.
- R12: Writing a 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. A new event arriving in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled count-enable pulse |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| pwm_out | output | 1 | Waveform output |
| irq_cmp | output | 1 | Compare flag |
| irq_ovf | output | 1 | Overflow flag |

## Verification
Each result has a fixed latency after its stimulus. The count and the waveform state change at the edge that samples the tick. `pwm_out` follows the state one edge later. Read data appears one edge after the address is presented, and both flags rise two edges after the tick cycle that caused them. The bench model updates at the same rising edges as the design and compares all four outputs at every falling edge. Directed checks hold `tick` low while reading back, and they sample the flags on the first and on the second falling edge after the event, so that each of these latencies is pinned to its exact cycle.

// File: rtl/tc8_pkg.sv
package tc8_pkg;
  typedef enum logic [1:0] {
    A_CNT = 2'd0,
    A_CMP = 2'd1,
    A_CTL = 2'd2,
    A_FLG = 2'd3
  } tc8_addr_t;

  typedef struct packed {
    logic invert;
    logic phase;
    logic pwm;
    logic run;
  } tc8_ctl_t;

  localparam int unsigned CTL_W = $bits(tc8_ctl_t);
endpackage

// File: rtl/tc8_regs.sv
module tc8_regs
  import tc8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     cnt,
  input  logic             ev_cmp,
  input  logic             ev_ovf,
  output tc8_ctl_t         ctl,
  output logic [W-1:0]     cmp_buf,
  output logic             irq_cmp,
  output logic             irq_ovf,
  output logic [W-1:0]     rdata
);
  logic flg_we;
  logic ctl_we;
  logic cmp_we;

  always_comb begin
    flg_we = we && (tc8_addr_t'(addr) == A_FLG);
    ctl_we = we && (tc8_addr_t'(addr) == A_CTL);
    cmp_we = we && (tc8_addr_t'(addr) == A_CMP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl     <= '0;
      cmp_buf <= '0;
      irq_cmp <= 1'b0;
      irq_ovf <= 1'b0;
      rdata   <= '0;
    end else begin
      if (ctl_we) ctl <= tc8_ctl_t'(wdata[CTL_W-1:0]);
      if (cmp_we) cmp_buf <= wdata;
      irq_cmp <= ev_cmp | (irq_cmp & ~(flg_we & wdata[0]));
      irq_ovf <= ev_ovf | (irq_ovf & ~(flg_we & wdata[1]));
      case (tc8_addr_t'(addr))
        A_CNT:   rdata <= cnt;
        A_CMP:   rdata <= cmp_buf;
        A_CTL:   rdata <= W'(ctl);
        default: rdata <= W'({irq_ovf, irq_cmp});
      endcase
    end
  end

  // R6
  ev_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ev_cmp |=> irq_cmp);

  // R12
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flg_we && wdata[0] && !ev_cmp |=> !irq_cmp);
endmodule

// File: rtl/tc8_count.sv
module tc8_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         run,
  input  logic         pwm,
  input  logic         phase,
  input  logic         cnt_we,
  input  logic         cmp_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cmp_buf,
  output logic [W-1:0] cnt,
  output logic         up,
  output logic         adv,
  output logic         at_top,
  output logic         match,
  output logic         ev_cmp,
  output logic         ev_ovf
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] act;
  logic         blk;
  logic         at_bot;
  logic         updn;
  logic [W-1:0] nxt;
  logic         nup;
  logic         ovf_c;

  always_comb begin
    adv    = tick & run;
    updn   = pwm & phase;
    at_top = (cnt == MAXV);
    at_bot = (cnt == '0);
    match  = adv & ~blk & (cnt == act);
    nxt    = cnt + ONE;
    nup    = 1'b1;
    if (updn) begin
      if (up) begin
        if (at_top) begin
          nxt = MAXV - ONE;
          nup = 1'b0;
        end
      end else if (at_bot) begin
        nxt = ONE;
      end else begin
        nxt = cnt - ONE;
        nup = 1'b0;
      end
    end
    ovf_c = adv & (updn ? (~up & at_bot) : at_top);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      up     <= 1'b1;
      blk    <= 1'b0;
      act    <= '0;
      ev_cmp <= 1'b0;
      ev_ovf <= 1'b0;
    end else begin
      ev_cmp <= match;
      ev_ovf <= ovf_c;
      if (cnt_we) begin
        cnt <= wdata;
        blk <= 1'b1;
      end else if (adv) begin
        cnt <= nxt;
        up  <= nup;
        blk <= 1'b0;
      end
      if (!pwm) act <= cmp_we ? wdata : cmp_buf;
      else if (adv && at_top) act <= cmp_buf;
    end
  end

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_we && !adv |=> $stable(cnt));

  // R4
  load_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> cnt == $past(wdata));

  // R5
  block_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cnt_we) && !cnt_we && adv |=> !ev_cmp);

  // R9
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    adv && !cnt_we && pwm && phase |=>
      (cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE));
endmodule

// File: rtl/tc8_wave.sv
module tc8_wave (
  input  logic clk,
  input  logic rst,
  input  logic pwm,
  input  logic phase,
  input  logic invert,
  input  logic adv,
  input  logic at_top,
  input  logic up,
  input  logic match,
  output logic pwm_out
);
  logic st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= 1'b1;
      pwm_out <= 1'b0;
    end else begin
      pwm_out <= pwm ? (st ^ invert) : 1'b0;
      if (!pwm) begin
        st <= 1'b1;
      end else if (phase) begin
        if (match) st <= ~up;
      end else if (adv && at_top) begin
        st <= 1'b1;
      end else if (match) begin
        st <= 1'b0;
      end
    end
  end

  // R10
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !pwm |=> !pwm_out);
endmodule

// File: rtl/tc8_cmp_pwm.sv
module tc8_cmp_pwm
  import tc8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         bus_we,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         pwm_out,
  output logic         irq_cmp,
  output logic         irq_ovf
);
  tc8_ctl_t     ctl;
  logic [W-1:0] cmp_buf;
  logic [W-1:0] cnt;
  logic         up, adv, at_top, match, ev_cmp, ev_ovf;
  logic         cnt_we, cmp_we;

  always_comb begin
    cnt_we = bus_we && (tc8_addr_t'(bus_addr) == A_CNT);
    cmp_we = bus_we && (tc8_addr_t'(bus_addr) == A_CMP);
  end

  tc8_regs #(.W(W)) regs_i (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .cnt(cnt), .ev_cmp(ev_cmp), .ev_ovf(ev_ovf), .ctl(ctl),
    .cmp_buf(cmp_buf), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf),
    .rdata(bus_rdata)
  );

  tc8_count #(.W(W)) count_i (
    .clk(clk), .rst(rst), .tick(tick), .run(ctl.run), .pwm(ctl.pwm),
    .phase(ctl.phase), .cnt_we(cnt_we), .cmp_we(cmp_we), .wdata(bus_wdata),
    .cmp_buf(cmp_buf), .cnt(cnt), .up(up), .adv(adv), .at_top(at_top),
    .match(match), .ev_cmp(ev_cmp), .ev_ovf(ev_ovf)
  );

  tc8_wave wave_i (
    .clk(clk), .rst(rst), .pwm(ctl.pwm), .phase(ctl.phase),
    .invert(ctl.invert), .adv(adv), .at_top(at_top), .up(up),
    .match(match), .pwm_out(pwm_out)
  );
endmodule

// File: tb/tc8_cmp_pwm_tb.sv
`timescale 1ns/1ps
module tc8_cmp_pwm_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       pwm_out, irq_cmp, irq_ovf;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tc8_cmp_pwm #(.W(8)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out),
    .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_act, m_buf, m_ctl, m_rd;
  bit m_up, m_blk, m_evc, m_evo, m_fc, m_fo, m_st, m_out;

  always @(posedge clk) begin
    int  n_cnt, n_act, n_buf, n_ctl, n_rd;
    bit  n_up, n_blk, n_fc, n_fo, n_st, n_out, n_evc, n_evo;
    bit  run, pwm, ph, inv, adv, hit, top;
    if (rst) begin
      m_cnt = 0; m_act = 0; m_buf = 0; m_ctl = 0; m_rd = 0;
      m_up = 1; m_blk = 0; m_evc = 0; m_evo = 0; m_fc = 0; m_fo = 0;
      m_st = 1; m_out = 0;
    end else begin
      run = m_ctl[0]; pwm = m_ctl[1]; ph = m_ctl[1] & m_ctl[2]; inv = m_ctl[3];
      adv = tick && run;
      hit = adv && !m_blk && (m_cnt == m_act);
      top = (m_cnt == 255);
      case (bus_addr)
        2'd0: n_rd = m_cnt;
        2'd1: n_rd = m_buf;
        2'd2: n_rd = m_ctl;
        default: n_rd = m_fo * 2 + m_fc;
      endcase
      n_out = pwm ? (m_st ^ inv) : 1'b0;
      n_st = m_st;
      if (!pwm) n_st = 1;
      else if (ph) begin
        if (hit) n_st = !m_up;
      end else if (adv && top) n_st = 1;
      else if (hit) n_st = 0;
      n_act = m_act;
      if (!pwm) n_act = (bus_we && bus_addr == 2'd1) ? int'(bus_wdata) : m_buf;
      else if (adv && top) n_act = m_buf;
      n_fc = m_evc || (m_fc && !(bus_we && bus_addr == 2'd3 && bus_wdata[0]));
      n_fo = m_evo || (m_fo && !(bus_we && bus_addr == 2'd3 && bus_wdata[1]));
      n_evc = hit;
      n_evo = adv && (ph ? (!m_up && m_cnt == 0) : top);
      n_cnt = m_cnt; n_up = m_up; n_blk = m_blk;
      if (bus_we && bus_addr == 2'd0) begin
        n_cnt = bus_wdata; n_blk = 1;
      end else if (adv) begin
        n_blk = 0;
        if (ph) begin
          if (m_up) begin
            if (top) begin n_cnt = 254; n_up = 0; end
            else n_cnt = m_cnt + 1;
          end else if (m_cnt == 0) begin n_cnt = 1; n_up = 1; end
          else n_cnt = m_cnt - 1;
        end else begin
          n_cnt = (m_cnt + 1) % 256; n_up = 1;
        end
      end
      n_buf = (bus_we && bus_addr == 2'd1) ? int'(bus_wdata) : m_buf;
      n_ctl = (bus_we && bus_addr == 2'd2) ? int'(bus_wdata & 8'h0f) : m_ctl;
      m_cnt = n_cnt; m_act = n_act; m_buf = n_buf; m_ctl = n_ctl; m_rd = n_rd;
      m_up = n_up; m_blk = n_blk; m_evc = n_evc; m_evo = n_evo;
      m_fc = n_fc; m_fo = n_fo; m_st = n_st; m_out = n_out;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 readback", int'(bus_rdata), m_rd);
      check("R6 compare flag", int'(irq_cmp), int'(m_fc));
      check("R7 overflow flag", int'(irq_ovf), int'(m_fo));
      if (!m_ctl[1]) check("R10 pwm_out", int'(pwm_out), int'(m_out));
      else if (m_ctl[2]) check("R9 pwm_out", int'(pwm_out), int'(m_out));
      else check("R8 pwm_out", int'(pwm_out), int'(m_out));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
    bus_addr = a;
    step(1);
    check(req, int'(bus_rdata), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(6);
    rst = 1'b0;
    step(1);
    // R1 reset state
    check("R1 pwm_out", int'(pwm_out), 0);
    check("R1 irq_cmp", int'(irq_cmp), 0);
    check("R1 irq_ovf", int'(irq_ovf), 0);
    for (int a = 0; a < 4; a++) rd_chk(2'(a), 0, "R1 register");

    // R3 hold while run is off
    tick = 1'b1; step(5); tick = 1'b0;
    rd_chk(2'd0, 0, "R3 hold with run off");

    // R4 write wins over step, then continues
    wr(2'd2, 8'h01);
    tick = 1'b1; wr(2'd0, 8'h10); tick = 1'b0;
    rd_chk(2'd0, 16, "R4 load priority");
    tick = 1'b1; step(1); tick = 1'b0;
    rd_chk(2'd0, 17, "R4 continue from load");
    rd_chk(2'd2, 1, "R2 control readback");

    // R5 write suppresses the next match
    wr(2'd1, 8'h40);
    wr(2'd3, 8'h03);
    wr(2'd0, 8'h40);
    tick = 1'b1; step(1); tick = 1'b0;
    step(2);
    check("R5 match masked after write", int'(irq_cmp), 0);

    // R6 flag latency
    wr(2'd0, 8'h3f);
    tick = 1'b1; step(2); tick = 1'b0;
    check("R6 flag not yet", int'(irq_cmp), 0);
    step(1);
    check("R6 flag set", int'(irq_cmp), 1);
    // R12 write-one clear
    wr(2'd3, 8'h02);
    check("R12 write zero keeps flag", int'(irq_cmp), 1);
    wr(2'd3, 8'h01);
    check("R12 clear", int'(irq_cmp), 0);

    // R7 wrap overflow
    wr(2'd0, 8'hff);
    tick = 1'b1; step(1); tick = 1'b0;
    step(1);
    check("R7 overflow on wrap", int'(irq_ovf), 1);
    rd_chk(2'd0, 0, "R7 wrap to zero");
    wr(2'd3, 8'h03);

    // R8 / R10 fast PWM start and inversion
    wr(2'd2, 8'h03);
    step(1);
    check("R8 fast starts high", int'(pwm_out), 1);
    wr(2'd2, 8'h0b);
    step(1);
    check("R10 inverted", int'(pwm_out), 0);
    wr(2'd2, 8'h03);

    // R11 buffered compare in PWM
    wr(2'd1, 8'h80);
    rd_chk(2'd1, 128, "R11 compare readback");
    tick = 1'b1; step(700);
    tick = 1'b0; wr(2'd1, 8'h20); tick = 1'b1;
    step(700);

    // R9 phase-correct stepping
    tick = 1'b0;
    wr(2'd2, 8'h07);
    wr(2'd0, 8'hfe);
    tick = 1'b1; step(3); tick = 1'b0;
    rd_chk(2'd0, 253, "R9 turn at top");
    for (int i = 0; i < 3000; i++) begin
      tick = (i % 2) == 0;
      step(1);
    end
    tick = 1'b0;
    wr(2'd2, 8'h0f);
    wr(2'd1, 8'h90);
    for (int i = 0; i < 1500; i++) begin
      tick = 1'b1;
      step(1);
    end

    // random traffic
    for (int i = 0; i < 30000; i++) begin
      tick = ($urandom % 3) != 0;
      if (($urandom % 48) == 0) begin
        bus_we = 1'b1;
        bus_addr = 2'($urandom % 4);
        bus_wdata = 8'($urandom);
        if (bus_addr == 2'd2) bus_wdata[0] = 1'b1;
      end else begin
        bus_we = 1'b0;
        bus_addr = 2'($urandom % 4);
      end
      step(1);
    end
    bus_we = 1'b0; tick = 1'b0;
    step(2);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule